// File: doc/BRIEF.md
# Write-Frame Clock Count Guard

This block protects a serial non-volatile memory from write-type frames whose length is wrong. It watches the synchronised chip-select level, a one-cycle pulse for each rising edge of the serial clock, and the serial data level. The first data-high edge after select rises is the start bit and is counted as clock 1. Clocks that arrive before it are padding and are not counted. From then until select drops, every serial clock edge adds one to a saturating counter.

When select falls, the block compares the count with the exact length that the decoded write-type command needs. The length depends on the address width parameter. A command that commits makes the block raise a one-cycle commit pulse to the memory-write engine. A write-type frame that fails the length check, or that arrives while program-enable is off, makes the block raise a one-cycle cancel pulse. In that case the memory-write engine does nothing. Read and mode-change frames pass through unjudged, and no pulse is raised for them.

Top module: `cmd_clk_guard`

## Requirements
- R1: Counting begins at the first serial clock edge that samples data high while select is high; that edge is clock 1. Edges that sample data low before it are not counted.
- R2: The opKind encoding is 0 none, 1 single-word write, 2 single-word erase, 3 write-all, 4 erase-all, 5 read, 6 enable-writes, 7 disable-writes.
- R3: Single-word write (1) and write-all (3) commit only when the count equals ADDR_W+19. That is 25 clocks at ADDR_W=6 and 27 clocks at ADDR_W=8.
- R4: Single-word erase (2) and erase-all (4) commit only when the count equals ADDR_W+3. That is 9 clocks at ADDR_W=6 and 11 clocks at ADDR_W=8.
- R5: A write-type frame whose count is one or more above or below its required length produces a cancel pulse and no commit pulse. This includes a disable-writes frame that is 10 clocks long because of one noise edge and is decoded as an erase.
- R6: A write-type frame of the correct length produces a cancel pulse and no commit pulse when wrEnable is low at the select fall.
- R7: Frames with opKind 0, 5, 6 or 7 produce neither pulse, whatever their length.
- R8: The counter saturates at its maximum value (63 at the default width). An 89-clock write frame, which a wrapping 6-bit counter would reduce to 25, is cancelled.
- R9: A write-type frame in which no start bit was seen produces neither pulse.
- R10: The decision is taken in the first cycle that samples select low. The pulse is high for exactly the following cycle. Commit and cancel are never high together.
- R11: While reset is asserted, and directly after it, both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csSync | input | 1 | Synchronised chip-select level |
| skRise | input | 1 | One-cycle pulse per serial clock rising edge |
| diSync | input | 1 | Synchronised serial data level |
| opKind | input | 3 | Decoded command code, valid at select fall |
| wrEnable | input | 1 | Program-enable mode level |
| commitPulse | output | 1 | Start the memory write for this frame |
| cancelPulse | output | 1 | Write-type frame rejected |

## Verification
A count that is off by one shows at the ports in the cycle after the frame ends. An exact-length frame then cancels, or a frame that is one clock long or short commits, so the bench tests every write-type command at its required length and at its two neighbours. A lost start-bit flag shows in the same way: frames with padding clocks in front commit or cancel wrongly, and frames with no start bit raise a pulse. A counter that wraps instead of saturating is caught only by a frame longer than the counter range, and the 89-clock case is chosen so that wrapping would land exactly on the commit length.

// File: rtl/guard_pkg.sv
`timescale 1ns/1ps
package guard_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WRALL = 3'd3,
    OP_ERALL = 3'd4,
    OP_READ  = 3'd5,
    OP_WREN  = 3'd6,
    OP_WRDIS = 3'd7
  } op_e;

  // strobes from control to the count datapath
  typedef struct packed {
    logic clearCnt;
    logic markStart;
    logic advance;
  } strobe_t;

  function automatic logic isLongWrite(op_e op);
    return (op == OP_WRITE) || (op == OP_WRALL);
  endfunction

  function automatic logic isShortWrite(op_e op);
    return (op == OP_ERASE) || (op == OP_ERALL);
  endfunction

endpackage

// File: rtl/clk_count_dp.sv
`timescale 1ns/1ps
module clk_count_dp
  import guard_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic [CNT_W-1:0] cnt,
  output logic             started
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      started <= 1'b0;
    end else if (stb.clearCnt) begin
      cnt     <= '0;
      started <= 1'b0;
    end else if (stb.markStart) begin
      cnt     <= {{(CNT_W-1){1'b0}}, 1'b1};
      started <= 1'b1;
    end else if (stb.advance && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/guard_ctrl.sv
`timescale 1ns/1ps
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csSync,
  input  logic             skRise,
  input  logic             diSync,
  input  logic [2:0]       opKind,
  input  logic             wrEnable,
  input  logic [CNT_W-1:0] cnt,
  input  logic             started,
  output strobe_t          stb,
  output logic             commitPulse,
  output logic             cancelPulse
);

  localparam int LONG_CLK  = ADDR_W + 19;
  localparam int SHORT_CLK = ADDR_W + 3;
  localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_CLK);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_CLK);

  logic csPrev;
  logic csFall;
  op_e  op;
  logic isWrite;
  logic lenOk;
  logic doCommit;
  logic doCancel;

  assign op     = op_e'(opKind);
  assign csFall = csPrev && !csSync;

  always_comb begin
    stb.clearCnt  = !csSync;
    stb.markStart = csSync && skRise && !started && diSync;
    stb.advance   = csSync && skRise && started;
  end

  always_comb begin
    isWrite = isLongWrite(op) || isShortWrite(op);
    if (isLongWrite(op))       lenOk = (cnt == LONG_CNT);
    else if (isShortWrite(op)) lenOk = (cnt == SHORT_CNT);
    else                       lenOk = 1'b0;
    doCommit = csFall && started && isWrite && lenOk && wrEnable;
    doCancel = csFall && started && isWrite && !(lenOk && wrEnable);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev      <= 1'b0;
      commitPulse <= 1'b0;
      cancelPulse <= 1'b0;
    end else begin
      csPrev      <= csSync;
      commitPulse <= doCommit;
      cancelPulse <= doCancel;
    end
  end

endmodule

// File: rtl/cmd_clk_guard.sv
`timescale 1ns/1ps
module cmd_clk_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csSync,
  input  logic       skRise,
  input  logic       diSync,
  input  logic [2:0] opKind,
  input  logic       wrEnable,
  output logic       commitPulse,
  output logic       cancelPulse
);

  localparam int LONG_CLK = ADDR_W + 19;
  localparam int CNT_W    = $clog2(LONG_CLK + 1) + 1;

  strobe_t          stb;
  logic [CNT_W-1:0] cntVal;
  logic             startSeen;

  guard_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csSync     (csSync),
    .skRise     (skRise),
    .diSync     (diSync),
    .opKind     (opKind),
    .wrEnable   (wrEnable),
    .cnt        (cntVal),
    .started    (startSeen),
    .stb        (stb),
    .commitPulse(commitPulse),
    .cancelPulse(cancelPulse)
  );

  clk_count_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cnt    (cntVal),
    .started(startSeen)
  );

endmodule

// File: rtl/guard_checker.sv
`timescale 1ns/1ps
module guard_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             csSync,
  input logic [2:0]       opKind,
  input logic             wrEnable,
  input logic             commitPulse,
  input logic             cancelPulse,
  input logic [CNT_W-1:0] cntVal
);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(commitPulse && cancelPulse));

  p_commit_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  p_cancel_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |=> !cancelPulse);

  p_commit_after_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> (!$past(csSync) && $past(csSync, 2)));

  p_commit_needs_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(wrEnable));

  p_commit_write_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> ($past(opKind) inside {3'd1, 3'd2, 3'd3, 3'd4}));

  p_cancel_write_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |-> ($past(opKind) inside {3'd1, 3'd2, 3'd3, 3'd4}));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(csSync) |-> (cntVal >= $past(cntVal)));

endmodule

bind cmd_clk_guard guard_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csSync     (csSync),
  .opKind     (opKind),
  .wrEnable   (wrEnable),
  .commitPulse(commitPulse),
  .cancelPulse(cancelPulse),
  .cntVal     (cntVal)
);

// File: tb/tb_cmd_clk_guard.sv
`timescale 1ns/1ps
module tb_cmd_clk_guard;

  logic       clk = 1'b0;
  logic       rstN;
  logic       csSync;
  logic       skRise;
  logic       diSync;
  logic [2:0] opKind;
  logic       wrEnable;
  logic       commit6, cancel6, commit8, cancel8;

  int checks   = 0;
  int failures = 0;
  logic done = 1'b0;

  // sampled results of the last frame
  logic gotC6, gotX6, gotC8, gotX8, tailHigh;

  always #4 clk = ~clk;

  cmd_clk_guard #(.ADDR_W(6)) dut (
    .clk(clk), .rstN(rstN), .csSync(csSync), .skRise(skRise), .diSync(diSync),
    .opKind(opKind), .wrEnable(wrEnable),
    .commitPulse(commit6), .cancelPulse(cancel6)
  );

  cmd_clk_guard #(.ADDR_W(8)) dut8 (
    .clk(clk), .rstN(rstN), .csSync(csSync), .skRise(skRise), .diSync(diSync),
    .opKind(opKind), .wrEnable(wrEnable),
    .commitPulse(commit8), .cancelPulse(cancel8)
  );

  task automatic check(string tag, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: {commit,cancel} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic frame(int nDummy, int nClk, logic [2:0] op, logic en);
    @(negedge clk);
    csSync = 1'b1; opKind = op; wrEnable = en; diSync = 1'b0;
    for (int i = 0; i < nDummy; i++) begin
      diSync = 1'b0; skRise = 1'b1; @(negedge clk);
      skRise = 1'b0; @(negedge clk);
    end
    for (int i = 0; i < nClk; i++) begin
      diSync = (i == 0) ? 1'b1 : ((i % 3) == 0);
      skRise = 1'b1; @(negedge clk);
      skRise = 1'b0; @(negedge clk);
    end
    csSync = 1'b0; diSync = 1'b0;
    @(negedge clk);
    gotC6 = commit6; gotX6 = cancel6; gotC8 = commit8; gotX8 = cancel8;
    @(negedge clk);
    tailHigh = commit6 | cancel6 | commit8 | cancel8;
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0; csSync = 1'b0; skRise = 1'b0; diSync = 1'b0;
    opKind = 3'd0; wrEnable = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 in reset 6", {commit6, cancel6}, 2'b00);
    check("R11 in reset 8", {commit8, cancel8}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after reset", {commit6, cancel6}, 2'b00);
  endtask

  task automatic testExactLengths();
    frame(0, 25, 3'd1, 1'b1);
    check("R3 write 25 clk a6", {gotC6, gotX6}, 2'b10);
    check("R10 pulse ends", {tailHigh, 1'b0}, 2'b00);
    frame(0, 25, 3'd3, 1'b1);
    check("R3 write-all 25 clk a6", {gotC6, gotX6}, 2'b10);
    frame(0, 9, 3'd2, 1'b1);
    check("R4 erase 9 clk a6", {gotC6, gotX6}, 2'b10);
    frame(0, 9, 3'd4, 1'b1);
    check("R4 erase-all 9 clk a6", {gotC6, gotX6}, 2'b10);
    frame(0, 27, 3'd1, 1'b1);
    check("R3 write 27 clk a8", {gotC8, gotX8}, 2'b10);
    check("R5 write 27 clk a6", {gotC6, gotX6}, 2'b01);
    frame(0, 11, 3'd4, 1'b1);
    check("R4 erase-all 11 clk a8", {gotC8, gotX8}, 2'b10);
    check("R2 R5 erase-all 11 clk a6", {gotC6, gotX6}, 2'b01);
  endtask

  task automatic testWrongLengths();
    frame(0, 24, 3'd1, 1'b1);
    check("R5 write 24 clk", {gotC6, gotX6}, 2'b01);
    frame(0, 26, 3'd3, 1'b1);
    check("R5 write-all 26 clk", {gotC6, gotX6}, 2'b01);
    frame(0, 8, 3'd2, 1'b1);
    check("R5 erase 8 clk", {gotC6, gotX6}, 2'b01);
    frame(0, 10, 3'd2, 1'b1);
    check("R5 noisy disable decoded as erase", {gotC6, gotX6}, 2'b01);
    check("R5 erase 10 clk a8", {gotC8, gotX8}, 2'b01);
  endtask

  task automatic testDummyClocks();
    frame(7, 25, 3'd1, 1'b1);
    check("R1 padding before start", {gotC6, gotX6}, 2'b10);
    frame(5, 9, 3'd2, 1'b1);
    check("R1 padding before erase", {gotC6, gotX6}, 2'b10);
  endtask

  task automatic testEnable();
    frame(0, 25, 3'd1, 1'b0);
    check("R6 write while disabled", {gotC6, gotX6}, 2'b01);
    frame(0, 9, 3'd4, 1'b0);
    check("R6 erase-all while disabled", {gotC6, gotX6}, 2'b01);
  endtask

  task automatic testUngated();
    frame(0, 25, 3'd5, 1'b1);
    check("R7 read", {gotC6, gotX6}, 2'b00);
    frame(0, 9, 3'd6, 1'b0);
    check("R7 enable-writes", {gotC6, gotX6}, 2'b00);
    frame(0, 12, 3'd7, 1'b1);
    check("R7 disable-writes", {gotC6, gotX6}, 2'b00);
    frame(0, 9, 3'd0, 1'b1);
    check("R7 none", {gotC6, gotX6}, 2'b00);
  endtask

  task automatic testSaturate();
    frame(0, 89, 3'd1, 1'b1);
    check("R8 89 clk write a6", {gotC6, gotX6}, 2'b01);
    frame(0, 75, 3'd2, 1'b1);
    check("R8 75 clk erase a6", {gotC6, gotX6}, 2'b01);
  endtask

  task automatic testNoStart();
    frame(6, 0, 3'd1, 1'b1);
    check("R9 no start bit", {gotC6, gotX6}, 2'b00);
    check("R9 no start bit a8", {gotC8, gotX8}, 2'b00);
  endtask

  initial begin
    testReset();
    testExactLengths();
    testWrongLengths();
    testDummyClocks();
    testEnable();
    testUngated();
    testSaturate();
    testNoStart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule